// File: doc/BRIEF.md
# Colour Channel Sequencer with Clamp Gating

This block is the digital control core of a three-colour line-sensor front end. It runs on the converter clock and picks which of the red, green and blue inputs feeds the single shared converter on each clock cycle. It also produces the internal input-clamp enable from the black-level sample pulse, the video sample pulse edge and the line-clamp input, under a two-bit clamp-mode field.

In colour mode the selection rotates green, blue, red on every converter-clock edge. The rotation is locked to the video sample pulse: the first rising clock edge that sees the pulse low after it was high forces the selection to green and raises a one-cycle sync flag. After reset, or after a return from single-colour mode, the selection holds still until that event arrives. In single-colour mode the chosen colour stays connected on every cycle.

Each cycle's selection is pushed, with a validity bit, into a fixed-latency tag pipe. The tag therefore reaches the output in step with the converter result, and downstream logic can split the stream back into colours. A sample is marked invalid when its channel was connected only on that same edge, because the converter had not yet been given a settled input.

Top module: `rgb_sequencer`

## Requirements
- R1: In colour mode (colour select 00), once synchronised, the mux select advances on every clock edge in the order green (10), blue (11), red (01), green, and so on.
- R2: In colour mode, a clock edge that samples the video pulse low, when the previous edge sampled it high, sets the mux select to green (10) and raises the sync flag for exactly that one cycle. At every other time the sync flag is low.
- R3: With a non-zero colour select (01 red, 10 green, 11 blue), the mux select takes that code on the next clock edge and keeps it, with no rotation. Video pulse edges have no effect on the select or the sync flag.
- R4: In colour mode before the first video-pulse fall after reset, or after leaving single-colour mode, the mux select holds its value and does not rotate.
- R5: The clamp enable is registered one cycle after its inputs. Mode 00 copies the black pulse, mode 01 gives black pulse AND line clamp, mode 11 copies line clamp, and mode 10 holds it low.
- R6: A synchronous active-high reset gives mux select red (01), clamp enable 0, sync flag 0, tag colour 00 and tag valid 0, with colour sequencing unsynchronised.
- R7: The tag outputs show the mux select and its validity bit exactly LAT clock cycles after they were current on the mux select output (LAT = 4 by default).
- R8: The validity bit is 0 for the cycle that starts at a resync edge, 0 in colour mode while unsynchronised, and 0 in single-colour mode on the first cycle after the select changes colour. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_smp_i | input | 1 | Black-level sample pulse |
| vid_smp_i | input | 1 | Video-level sample pulse |
| line_clamp_i | input | 1 | Line-clamp input |
| clamp_mode_i | input | 2 | Clamp mode: 00 pixel, 01 line, 10 off, 11 sample-hold line |
| color_sel_i | input | 2 | 00 colour sequencing, 01 red, 10 green, 11 blue |
| mux_sel_o | output | 2 | Converter input select (01 red, 10 green, 11 blue) |
| clamp_en_o | output | 1 | Internal input-clamp enable |
| sync_o | output | 1 | One-cycle flag on a resync to green |
| tag_color_o | output | 2 | Colour of the sample leaving the converter |
| tag_valid_o | output | 1 | Sample is valid (not a dummy) |

## Verification
The hardest state to reach from the ports is the return from single-colour mode into colour mode while the video pulse is already running. There the select must freeze until the next pulse fall, and the first tag after the resync must come out invalid. The stimulus keeps the video pulse running with irregular periods and drops in single-colour stretches of varying length and colour. Every return to colour mode then lands at a different phase of the pulse. A cycle-accurate model in the bench follows the pipe latency, so each tag is compared LAT cycles after its selection was made.

// File: rtl/rgbseq_pkg.sv
package rgbseq_pkg;
  localparam logic [1:0] COL_TRI = 2'b00;
  localparam logic [1:0] COL_RED = 2'b01;
  localparam logic [1:0] COL_GRN = 2'b10;
  localparam logic [1:0] COL_BLU = 2'b11;

  localparam logic [1:0] CLM_PIX  = 2'b00;
  localparam logic [1:0] CLM_LINE = 2'b01;
  localparam logic [1:0] CLM_OFF  = 2'b10;
  localparam logic [1:0] CLM_SH   = 2'b11;

  function automatic logic [1:0] next_colour(input logic [1:0] c);
    case (c)
      COL_GRN: next_colour = COL_BLU;
      COL_BLU: next_colour = COL_RED;
      default: next_colour = COL_GRN;
    endcase
  endfunction
endpackage

// File: rtl/clamp_gate.sv
module clamp_gate
  import rgbseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       blk_i,
  input  logic       lcl_i,
  input  logic [1:0] mode_i,
  output logic       clamp_o
);
  logic clamp_d;

  always_comb begin
    case (mode_i)
      CLM_PIX:  clamp_d = blk_i;
      CLM_LINE: clamp_d = blk_i & lcl_i;
      CLM_SH:   clamp_d = lcl_i;
      default:  clamp_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) clamp_o <= 1'b0;
    else     clamp_o <= clamp_d;
  end

  // R5: with the clamp switched off, the enable stays low on the next cycle
  p_clamp_off_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == CLM_OFF) |=> !clamp_o);
  // R5: pixel mode follows the black pulse one cycle later
  p_clamp_pix_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == CLM_PIX) |=> (clamp_o == $past(blk_i)));
endmodule

// File: rtl/chan_rotor.sv
module chan_rotor
  import rgbseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       vid_i,
  input  logic [1:0] csel_i,
  output logic [1:0] sel_o,
  output logic       sync_o,
  output logic       live_o
);
  logic vid_q;
  logic running;
  logic fall;
  logic tri_mode;

  assign fall     = vid_q & ~vid_i;
  assign tri_mode = (csel_i == COL_TRI);

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_q   <= 1'b0;
      running <= 1'b0;
      sel_o   <= COL_RED;
      sync_o  <= 1'b0;
      live_o  <= 1'b0;
    end else begin
      vid_q <= vid_i;
      if (!tri_mode) begin
        sel_o   <= csel_i;
        running <= 1'b0;
        sync_o  <= 1'b0;
        live_o  <= (sel_o == csel_i);
      end else if (fall) begin
        sel_o   <= COL_GRN;
        running <= 1'b1;
        sync_o  <= 1'b1;
        live_o  <= 1'b0;
      end else begin
        sync_o <= 1'b0;
        live_o <= running;
        if (running) sel_o <= next_colour(sel_o);
      end
    end
  end

  // R2: a resync always lands on green
  p_sync_green_r2: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> (sel_o == COL_GRN));
  // R2: the sync flag lasts a single cycle
  p_sync_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> !sync_o);
  // R1: once synchronised, colour mode never repeats a colour on consecutive cycles
  p_rotate_r1: assert property (@(posedge clk) disable iff (rst)
    (tri_mode && running && !fall) |=> (sel_o != $past(sel_o)));
  // R3: single-colour mode connects the chosen colour on the next edge
  p_single_r3: assert property (@(posedge clk) disable iff (rst)
    !tri_mode |=> (sel_o == $past(csel_i)) && !sync_o);
  // R4: unsynchronised colour mode holds the select
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (tri_mode && !running && !fall) |=> $stable(sel_o));
endmodule

// File: rtl/tag_pipe.sv
module tag_pipe #(
  parameter int LAT = 4,
  parameter int W   = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d_i;
      for (int i = 1; i < LAT; i++) stage[i] <= stage[i-1];
    end
  end

  assign q_o = stage[LAT-1];
endmodule

// File: rtl/rgb_sequencer.sv
module rgb_sequencer
  import rgbseq_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       blk_smp_i,
  input  logic       vid_smp_i,
  input  logic       line_clamp_i,
  input  logic [1:0] clamp_mode_i,
  input  logic [1:0] color_sel_i,
  output logic [1:0] mux_sel_o,
  output logic       clamp_en_o,
  output logic       sync_o,
  output logic [1:0] tag_color_o,
  output logic       tag_valid_o
);
  localparam int TAG_W = 3;

  logic             live;
  logic [TAG_W-1:0] tag_in;
  logic [TAG_W-1:0] tag_out;

  clamp_gate u_clamp (
    .clk(clk), .rst(rst), .blk_i(blk_smp_i), .lcl_i(line_clamp_i),
    .mode_i(clamp_mode_i), .clamp_o(clamp_en_o)
  );

  chan_rotor u_rotor (
    .clk(clk), .rst(rst), .vid_i(vid_smp_i), .csel_i(color_sel_i),
    .sel_o(mux_sel_o), .sync_o(sync_o), .live_o(live)
  );

  assign tag_in = {live, mux_sel_o};

  tag_pipe #(.LAT(LAT), .W(TAG_W)) u_pipe (
    .clk(clk), .rst(rst), .d_i(tag_in), .q_o(tag_out)
  );

  assign tag_valid_o = tag_out[2];
  assign tag_color_o = tag_out[1:0];

  // R8: a valid tag always names a real colour
  p_tag_colour_r8: assert property (@(posedge clk) disable iff (rst)
    tag_valid_o |-> (tag_color_o != COL_TRI));
  // R2: a sync flag marks the start of a dummy sample
  p_sync_dummy_r8: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> !live);
endmodule

// File: tb/rgb_sequencer_bench.sv
module rgb_sequencer_bench;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blk = 1'b0, vid = 1'b0, lcl = 1'b0;
  logic [1:0] cm = 2'b00, cs = 2'b00;
  logic [1:0] sel, tcol;
  logic clamp, sync, tval;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rgb_sequencer #(.LAT(LAT)) u_rgb_sequencer (
    .clk(clk), .rst(rst), .blk_smp_i(blk), .vid_smp_i(vid),
    .line_clamp_i(lcl), .clamp_mode_i(cm), .color_sel_i(cs),
    .mux_sel_o(sel), .clamp_en_o(clamp), .sync_o(sync),
    .tag_color_o(tcol), .tag_valid_o(tval)
  );

  // model state: values expected after the most recent edge
  logic       m_vq, m_run, m_sync, m_live, m_clamp;
  logic [1:0] m_sel;
  logic [2:0] hist [LAT];
  logic       last_tri_run;

  function automatic logic [1:0] rot(input logic [1:0] c);
    return (c == 2'b10) ? 2'b11 : (c == 2'b11) ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_vq = 0; m_run = 0; m_sync = 0; m_live = 0; m_clamp = 0; m_sel = 2'b01;
    for (int i = 0; i < LAT; i++) hist[i] = 3'b000;
  endtask

  task automatic model_step();
    logic fall;
    logic [2:0] h0;
    fall = m_vq & ~vid;
    h0 = {m_live, m_sel};
    for (int i = LAT - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = h0;
    case (cm)
      2'b00: m_clamp = blk;
      2'b01: m_clamp = blk & lcl;
      2'b11: m_clamp = lcl;
      default: m_clamp = 1'b0;
    endcase
    last_tri_run = 0;
    if (cs != 2'b00) begin
      m_live = (m_sel == cs); m_sel = cs; m_run = 0; m_sync = 0;
    end else if (fall) begin
      m_sel = 2'b10; m_run = 1; m_sync = 1; m_live = 0;
    end else begin
      m_sync = 0; m_live = m_run;
      if (m_run) begin m_sel = rot(m_sel); last_tri_run = 1; end
    end
    m_vq = vid;
  endtask

  task automatic compare_all();
    string sreq;
    sreq = (cs != 2'b00) ? "R3" : last_tri_run ? "R1" : "R4";
    chk(sreq, sel, m_sel);
    chk("R2", sync, m_sync);
    chk("R5", clamp, m_clamp);
    chk("R7", tcol, hist[LAT-1][1:0]);
    chk("R8", tval, hist[LAT-1][2]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int vcnt;
    int scnt;
    lfsr = 16'hACE1;
    vcnt = 0;
    scnt = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R6: reset state
    chk("R6", sel, 2'b01);
    chk("R6", clamp, 0);
    chk("R6", sync, 0);
    chk("R6", tcol, 0);
    chk("R6", tval, 0);
    rst = 1'b0;

    // R5: exhaustive clamp table in single-colour red mode
    cs = 2'b01;
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        cm = m[1:0]; blk = p[0]; lcl = p[1];
        model_step();
        @(negedge clk);
        compare_all();
      end
    end

    // R4: colour mode without a video fall keeps the select still
    cs = 2'b00; vid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      model_step();
      @(negedge clk);
      compare_all();
    end

    // mixed sweep: irregular video pulses, single-colour stretches
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      blk = lfsr[0];
      lcl = lfsr[3];
      if (c % 41 == 0) cm = lfsr[5:4];
      if (scnt > 0) begin
        scnt--;
        if (scnt == 0) cs = 2'b00;
      end else if (lfsr[15:10] == 6'd7) begin
        cs = (lfsr[9:8] == 2'b00) ? 2'b10 : lfsr[9:8];
        scnt = 3 + lfsr[7:3];
      end else if (scnt == 0 && cs != 2'b00 && lfsr[2]) begin
        cs = lfsr[9:8];
      end
      vcnt++;
      if (vcnt >= 3 + (lfsr[11] ? 1 : 0) + (lfsr[12] ? 2 : 0)) begin
        vcnt = 0;
        vid = 1'b1;
      end else begin
        vid = 1'b0;
      end
      model_step();
      @(negedge clk);
      compare_all();
    end

    // R6: reset mid-run returns to the reset state
    rst = 1'b1;
    @(negedge clk);
    model_reset();
    chk("R6", sel, 2'b01);
    chk("R6", sync, 0);
    chk("R6", tval, 0);
    rst = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule